// File: doc/BRIEF.md
# Prioritized External Bus Arbiter

This block decides which of five requesters owns a single external bus. The requesters are an outside device asking for bus hold, a DMA engine, CPU operand accesses, CPU fetches after a branch and CPU sequential fetches. Each one raises a request and watches its grant bit. The bus sequencer that runs the actual cycles pulses `done_i` in the last clock of each cycle. The arbiter only changes its decision at that point, or at any clock while the bus is idle.

Two rules can override plain priority. A requester that needs several back-to-back accesses for one instruction can keep the bus by raising its lock bit. A read-modify-write opens one slot between the read and the write, and only an instruction fetch may use that slot.

Top module: `ext_bus_arbiter`

## Requirements
- R1: Source bits are 0 = bus hold, 1 = DMA, 2 = operand, 3 = branch fetch, 4 = sequential fetch. Under free arbitration the lowest-numbered requesting source is granted.
- R2: `gnt_o` has at most one bit set. If an arbitration point finds no eligible request, the bus is left with no grant.
- R3: While a grant is held and `done_i` is low, `gnt_o` does not change. This holds even when the request drops or a higher-priority request arrives.
- R4: When the bus is idle, an eligible request is granted on the next clock edge.
- R5: A lock is taken when the granted DMA (bit 1) or operand (bit 2) source completes a cycle with its own `lock_i` bit high and, for the operand source, `rmw_i` low.
  - While the lock is held, only that source can be granted. All other requests wait, and the bus idles if the lock holder is not requesting.
  - The lock is released when the holder completes a cycle with its lock bit low.
  - `lock_i` bits 0, 3 and 4 have no effect.
- R6: When the operand source completes a read with `rmw_i` high, the next grant behaves as follows.
  - If a fetch is requesting, the grant goes to a fetch source, with the branch fetch ahead of the sequential fetch.
  - Otherwise the grant goes to the operand source.
  - Bus hold and DMA are not granted.
- R7: After a fetch completes in the read-modify-write slot, only the operand source (the write) can be granted next.
- R8: When the write of a read-modify-write completes, free arbitration resumes, and `rmw_i` is ignored on that completion.
- R9: Reset clears the grant, any lock and any read-modify-write state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Request per source, bit numbering as in R1 |
| lock_i | input | 5 | Keep-bus flag per source, sampled with `done_i` |
| rmw_i | input | 1 | Operand cycle completing now is the read of a read-modify-write |
| done_i | input | 1 | Current bus cycle finishes this clock |
| gnt_o | output | 5 | One-hot grant, bit numbering as in R1 |

## Verification
The first pattern is a staircase of requests, where each completion removes the current winner. It shows whether the priority order is applied correctly at every level. A second pattern raises higher-priority requests, or drops the request, in the middle of a cycle, which separates arbitration on every clock from arbitration only at cycle boundaries. Lock sequences are driven in three forms: with the holder requesting, with the holder silent while all other sources request, and with lock bits set on sources that cannot lock. These show the difference between keeping the bus, blocking others and ignoring a lock. Read-modify-write runs are driven with a fetch waiting, with no fetch waiting and with a fetch that arrives late, which tests the single fetch slot and the return of the grant to the write.

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] req_i,
  input  logic [4:0] lock_i,
  input  logic       rmw_i,
  input  logic       done_i,
  output logic [4:0] gnt_o
);
  localparam logic [4:0] OPB   = 5'b00100;
  localparam logic [4:0] LOCKS = 5'b00110;
  localparam logic [4:0] FETCH = 5'b11000;

  typedef enum logic [1:0] {M_FREE, M_LOCK, M_GAP, M_WPEND} mode_t;

  mode_t      mode_q, mode_d;
  logic [4:0] gnt_q, own_q, own_d, mask, cand, pick;

  wire busy = |gnt_q;
  wire fin  = busy && done_i;
  wire arb  = !busy || done_i;

  always_comb begin
    mode_d = mode_q;
    own_d  = own_q;
    if (fin) begin
      case (mode_q)
        M_FREE, M_LOCK: begin
          if ((gnt_q & OPB) != 0 && rmw_i) begin
            mode_d = M_GAP;
            own_d  = '0;
          end else if ((gnt_q & LOCKS & lock_i) != 0) begin
            mode_d = M_LOCK;
            own_d  = gnt_q;
          end else begin
            mode_d = M_FREE;
            own_d  = '0;
          end
        end
        M_GAP:   mode_d = ((gnt_q & FETCH) != 0) ? M_WPEND : M_FREE;
        default: mode_d = M_FREE;
      endcase
    end
  end

  always_comb begin
    case (mode_d)
      M_LOCK:  mask = own_d;
      M_GAP:   mask = ((req_i & FETCH) != 0) ? FETCH : OPB;
      M_WPEND: mask = OPB;
      default: mask = '1;
    endcase
  end

  assign cand  = req_i & mask;
  assign pick  = cand & (~cand + 5'd1);
  assign gnt_o = gnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      own_q  <= '0;
      mode_q <= M_FREE;
    end else begin
      mode_q <= mode_d;
      own_q  <= own_d;
      if (arb) gnt_q <= pick;
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != 0 && !done_i) |=> $stable(gnt_o));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == 0 && req_i != 0 && mode_q == M_FREE) |=> gnt_o != 0);

  assert_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o[2] && done_i && lock_i[2] && !rmw_i && mode_q != M_GAP && mode_q != M_WPEND)
      |=> (gnt_o & ~OPB) == 0);

  assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o[2] && done_i && rmw_i && (mode_q == M_FREE || mode_q == M_LOCK))
      |=> (gnt_o[1:0] == 2'b00));

  assert_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o & FETCH) != 0 && done_i && mode_q == M_GAP) |=> (gnt_o & ~OPB) == 0);

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |=> gnt_o == 0);
endmodule

// File: tb/ext_bus_arbiter_bench.sv
module ext_bus_arbiter_bench;
  logic clk = 0, rst_n = 0, rmw = 0, done = 0;
  logic [4:0] req = 0, lock = 0, gnt;
  int checks = 0, errors = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  ext_bus_arbiter u_ext_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock),
    .rmw_i(rmw), .done_i(done), .gnt_o(gnt));

  task automatic cyc(input logic [4:0] r, input logic [4:0] l, input logic m,
                     input logic d, input logic [4:0] e, input string t);
    @(negedge clk);
    req = r; lock = l; rmw = m; done = d;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (gnt !== e) begin
        errors++;
        $display("FAIL %s gnt=%b expected=%b", t, gnt, e);
      end
    end
  end

  initial begin
    #4000;
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (gnt !== 5'b0) begin
      errors++;
      $display("FAIL R9 gnt=%b expected=00000", gnt);
    end
    rst_n = 1;
    // R1/R2/R3/R4 priority staircase
    cyc(5'b00000, 0, 0, 0, 5'b00000, "R2 idle");
    cyc(5'b11111, 0, 0, 0, 5'b00001, "R4 R1 hold first");
    cyc(5'b11110, 0, 0, 0, 5'b00001, "R3 held without done");
    cyc(5'b11110, 0, 0, 1, 5'b00010, "R1 dma");
    cyc(5'b11100, 0, 0, 1, 5'b00100, "R1 operand");
    cyc(5'b11000, 0, 0, 1, 5'b01000, "R1 branch");
    cyc(5'b10000, 0, 0, 1, 5'b10000, "R1 sequential");
    cyc(5'b00000, 0, 0, 1, 5'b00000, "R2 no request");
    cyc(5'b10000, 0, 0, 0, 5'b10000, "R4 sequential from idle");
    cyc(5'b00001, 0, 0, 0, 5'b10000, "R3 higher waits");
    cyc(5'b00001, 0, 0, 1, 5'b00001, "R1 hold at boundary");
    cyc(5'b00000, 0, 0, 1, 5'b00000, "R2 idle");
    // R5 lock
    cyc(5'b00100, 0, 0, 0, 5'b00100, "R4 operand");
    cyc(5'b11101, 5'b00100, 0, 1, 5'b00100, "R5 locked regrant");
    cyc(5'b11011, 5'b00100, 0, 1, 5'b00000, "R5 others blocked");
    cyc(5'b11011, 5'b00000, 0, 0, 5'b00000, "R5 still blocked idle");
    cyc(5'b11111, 5'b00000, 0, 0, 5'b00100, "R5 holder returns");
    cyc(5'b11011, 5'b00000, 0, 1, 5'b00001, "R5 release");
    cyc(5'b00000, 0, 0, 1, 5'b00000, "R2 idle");
    cyc(5'b01000, 5'b01000, 0, 0, 5'b01000, "R4 branch");
    cyc(5'b10001, 5'b11001, 0, 1, 5'b00001, "R5 fetch lock ignored");
    cyc(5'b00000, 0, 0, 1, 5'b00000, "R2 idle");
    // R6/R7/R8 read-modify-write
    cyc(5'b00100, 0, 0, 0, 5'b00100, "R4 operand read");
    cyc(5'b11110, 0, 1, 1, 5'b01000, "R6 branch in slot");
    cyc(5'b11111, 0, 0, 1, 5'b00100, "R7 write next");
    cyc(5'b11111, 0, 1, 1, 5'b00001, "R8 free after write");
    cyc(5'b00000, 0, 0, 1, 5'b00000, "R2 idle");
    cyc(5'b00100, 0, 0, 0, 5'b00100, "R4 operand read");
    cyc(5'b00111, 0, 1, 1, 5'b00100, "R6 no fetch write");
    cyc(5'b00011, 0, 0, 1, 5'b00001, "R8 free after write");
    cyc(5'b00000, 0, 0, 1, 5'b00000, "R2 idle");
    cyc(5'b00100, 0, 0, 0, 5'b00100, "R4 operand read");
    cyc(5'b00011, 0, 1, 1, 5'b00000, "R6 slot excludes hold dma");
    cyc(5'b10011, 0, 0, 0, 5'b10000, "R6 late sequential fetch");
    cyc(5'b00111, 0, 0, 1, 5'b00100, "R7 write after fetch");
    cyc(5'b00000, 0, 0, 1, 5'b00000, "R2 idle");
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule